// File: doc/BRIEF.md
# Micro-op Fission Dispatch Unit

This unit sits after a single narrow decoder and feeds the rename stages of several hardware thread contexts. Each cycle it can take one decoded micro-op. A plain micro-op goes to the context that fetched it. A micro-op marked for cloning is copied into the queue of every context in the active set, so one decode slot fills several back-end lanes. Each copy carries a lane immediate. In multi-assign form, context k takes element k of the immediate vector. In broadcast form, every copy takes element 0.

Three control micro-ops act on the unit itself. A fork loads the active-context set. A join holds all further dispatch until every context's reorder buffer reports empty. A conditional flush empties the queue of a context that has left a loop and drops that context from the active set, while the other contexts keep running. Each context has a small FIFO in front of its rename stage, with a valid/ready handshake on the output side.

Top module: `uop_fission_dispatch`

## Requirements
- R1: When the active set is not empty, an accepted plain micro-op with `in_clone`=1 is written in the same cycle into the queue of every context whose bit is set in the active set, and into no other queue.
- R2: An accepted plain micro-op with `in_clone`=0 is written only into the queue of context `in_ctx`.
- R3: The copy for context k carries `in_op` and a lane immediate. With `in_multi`=1 the lane immediate is `in_imm_vec[k*IMM_W +: IMM_W]`. With `in_multi`=0 it is element 0 for every context.
- R4: When the active set is empty, a cloned micro-op goes only to context `in_ctx`.
- R5: `in_kind` 2 (join) is accepted at once. If not every `rob_empty` bit is 1 at that edge, `in_ready` stays 0 from the next cycle on. It returns to 1 in the cycle after an edge at which all `rob_empty` bits are 1. A join that arrives while all bits are 1 causes no stall.
- R6: `in_kind` 3 (flush) empties the queue of context `in_ctx` and clears that context's bit in the active set. It leaves the other queues untouched.
- R7: A plain micro-op is accepted only when every one of its target queues has a free slot. Otherwise `in_ready` is 0 and no queue is written. Each queue holds `QDEPTH` entries (4 by default).
- R8: `in_kind` 1 (fork) loads the active set from the low `NCTX` bits of element 0 of `in_imm_vec`. `in_kind` 0 is a plain micro-op.
- R9: Synchronous active-high `rst` empties all queues, clears the active set and releases the barrier.
- R10: Each queue presents entries in arrival order. `out_valid[k]` is 1 while it holds an entry, and an entry leaves on a clock edge with `out_valid[k]` and `out_ready[k]` both 1. Context k uses bits `[k*OP_W +: OP_W]` of `out_op` and bits `[k*IMM_W +: IMM_W]` of `out_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded micro-op present |
| in_ready | output | 1 | Micro-op accepted on this edge |
| in_kind | input | 2 | 0 plain, 1 fork, 2 join, 3 flush |
| in_clone | input | 1 | Replicate the micro-op across the active set |
| in_multi | input | 1 | Per-lane immediate selection |
| in_ctx | input | CTX_W | Fetching context |
| in_op | input | OP_W | Micro-op payload |
| in_imm_vec | input | NCTX*IMM_W | Immediate vector, one element per context |
| out_valid | output | NCTX | Queue head valid, per context |
| out_ready | input | NCTX | Rename stage takes the head, per context |
| out_op | output | NCTX*OP_W | Head payload, per context |
| out_imm | output | NCTX*IMM_W | Head lane immediate, per context |
| rob_empty | input | NCTX | Reorder buffer empty, per context |

## Verification
The bench builds the unit with its defaults: two contexts, four-deep queues and 8-bit fields. This small shape lets it sweep every active-set value against every combination of clone flag, lane mode and fetching context, and compare each queue head with an expected value computed independently. With four-deep queues, a few plain micro-ops are enough to fill one queue and show that a cloned micro-op is refused as a whole. Barrier hold and release, a flush with live entries in both queues, and a reset in mid-run are each driven as a directed sequence.

// File: rtl/fission_pkg.sv
package fission_pkg;
  typedef enum logic [1:0] {
    UOP_PLAIN = 2'd0,
    UOP_FORK  = 2'd1,
    UOP_JOIN  = 2'd2,
    UOP_FLUSH = 2'd3
  } uop_kind_e;
endpackage

// File: rtl/ctx_fifo.sv
module ctx_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             valid,
  output logic [WIDTH-1:0] head,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign valid   = (count != '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign head    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fission_router.sv
module fission_router
  import fission_pkg::*;
#(
  parameter int NCTX  = 2,
  parameter int CTX_W = 1,
  parameter int OP_W  = 8,
  parameter int IMM_W = 8
) (
  input  logic                         in_valid,
  input  logic [1:0]                   in_kind,
  input  logic                         in_clone,
  input  logic                         in_multi,
  input  logic [CTX_W-1:0]             in_ctx,
  input  logic [OP_W-1:0]              in_op,
  input  logic [NCTX*IMM_W-1:0]        in_imm_vec,
  input  logic [NCTX-1:0]              active_mask,
  input  logic [NCTX-1:0]              q_full,
  input  logic                         barrier_busy,
  output logic                         in_ready,
  output logic [NCTX-1:0]              push,
  output logic [NCTX*(OP_W+IMM_W)-1:0] push_entry,
  output logic                         join_req,
  output logic [NCTX-1:0]              flush_vec,
  output logic                         fork_load,
  output logic [NCTX-1:0]              fork_mask
);
  localparam int ENT_W = OP_W + IMM_W;

  uop_kind_e       kind;
  logic [NCTX-1:0] own, targets;
  logic            blocked, accept;

  function automatic logic [NCTX-1:0] ctx_onehot(input logic [CTX_W-1:0] c);
    logic [NCTX-1:0] oh;
    for (int k = 0; k < NCTX; k++) oh[k] = (c == CTX_W'(k));
    return oh;
  endfunction

  function automatic logic [NCTX-1:0] target_set(input logic clone,
                                                 input logic [NCTX-1:0] mask,
                                                 input logic [NCTX-1:0] self);
    if (clone && (mask != '0)) return mask;
    return self;
  endfunction

  function automatic logic [IMM_W-1:0] lane_imm(input logic [NCTX*IMM_W-1:0] vec,
                                                input int k, input logic multi);
    return multi ? vec[k*IMM_W +: IMM_W] : vec[0 +: IMM_W];
  endfunction

  assign fork_mask = in_imm_vec[NCTX-1:0];

  always_comb begin
    kind      = uop_kind_e'(in_kind);
    own       = ctx_onehot(in_ctx);
    targets   = (kind == UOP_PLAIN) ? target_set(in_clone, active_mask, own) : '0;
    blocked   = |(targets & q_full);
    in_ready  = !barrier_busy && !blocked;
    accept    = in_valid && in_ready;
    push      = accept ? targets : '0;
    join_req  = accept && (kind == UOP_JOIN);
    fork_load = accept && (kind == UOP_FORK);
    flush_vec = (accept && (kind == UOP_FLUSH)) ? own : '0;
    for (int k = 0; k < NCTX; k++)
      push_entry[k*ENT_W +: ENT_W] = {in_op, lane_imm(in_imm_vec, k, in_multi)};
  end
endmodule

// File: rtl/join_barrier.sv
module join_barrier #(
  parameter int NCTX = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            join_req,
  input  logic [NCTX-1:0] rob_empty,
  output logic            busy
);
  logic all_empty;
  assign all_empty = &rob_empty;

  always_ff @(posedge clk) begin
    if (rst)                        busy <= 1'b0;
    else if (busy && all_empty)     busy <= 1'b0;
    else if (join_req && !all_empty) busy <= 1'b1;
  end
endmodule

// File: rtl/ctx_mask_reg.sv
module ctx_mask_reg #(
  parameter int NCTX = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fork_load,
  input  logic [NCTX-1:0] fork_mask,
  input  logic [NCTX-1:0] flush_vec,
  output logic [NCTX-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)            mask <= '0;
    else if (fork_load) mask <= fork_mask;
    else                mask <= mask & ~flush_vec;
  end
endmodule

// File: rtl/uop_fission_dispatch.sv
module uop_fission_dispatch #(
  parameter int NCTX   = 2,
  parameter int OP_W   = 8,
  parameter int IMM_W  = 8,
  parameter int QDEPTH = 4,
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_kind,
  input  logic                  in_clone,
  input  logic                  in_multi,
  input  logic [CTX_W-1:0]      in_ctx,
  input  logic [OP_W-1:0]       in_op,
  input  logic [NCTX*IMM_W-1:0] in_imm_vec,
  output logic [NCTX-1:0]       out_valid,
  input  logic [NCTX-1:0]       out_ready,
  output logic [NCTX*OP_W-1:0]  out_op,
  output logic [NCTX*IMM_W-1:0] out_imm,
  input  logic [NCTX-1:0]       rob_empty
);
  localparam int ENT_W = OP_W + IMM_W;

  logic [NCTX-1:0]       push, q_full, flush_vec, active_mask, fork_mask;
  logic [NCTX*ENT_W-1:0] push_entry;
  logic                  join_req, fork_load, barrier_busy;

  fission_router #(.NCTX(NCTX), .CTX_W(CTX_W), .OP_W(OP_W), .IMM_W(IMM_W)) u_router (
    .in_valid(in_valid), .in_kind(in_kind), .in_clone(in_clone), .in_multi(in_multi),
    .in_ctx(in_ctx), .in_op(in_op), .in_imm_vec(in_imm_vec),
    .active_mask(active_mask), .q_full(q_full), .barrier_busy(barrier_busy),
    .in_ready(in_ready), .push(push), .push_entry(push_entry), .join_req(join_req),
    .flush_vec(flush_vec), .fork_load(fork_load), .fork_mask(fork_mask)
  );

  join_barrier #(.NCTX(NCTX)) u_barrier (
    .clk(clk), .rst(rst), .join_req(join_req), .rob_empty(rob_empty), .busy(barrier_busy)
  );

  ctx_mask_reg #(.NCTX(NCTX)) u_mask (
    .clk(clk), .rst(rst), .fork_load(fork_load), .fork_mask(fork_mask),
    .flush_vec(flush_vec), .mask(active_mask)
  );

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    logic [ENT_W-1:0] head;
    ctx_fifo #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst(rst), .clear(flush_vec[k]),
      .push(push[k]), .push_data(push_entry[k*ENT_W +: ENT_W]),
      .pop(out_ready[k]), .valid(out_valid[k]), .head(head), .full(q_full[k])
    );
    assign out_op[k*OP_W +: OP_W]    = head[ENT_W-1 -: OP_W];
    assign out_imm[k*IMM_W +: IMM_W] = head[IMM_W-1:0];
  end
endmodule

// File: rtl/fission_dispatch_checker.sv
module fission_dispatch_checker #(
  parameter int NCTX = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_kind,
  input logic            in_clone,
  input logic [NCTX-1:0] push,
  input logic [NCTX-1:0] q_full,
  input logic [NCTX-1:0] active_mask,
  input logic            barrier_busy,
  input logic [NCTX-1:0] flush_vec,
  input logic [NCTX-1:0] out_valid
);
  logic plain_acc;
  assign plain_acc = in_valid && in_ready && (in_kind == 2'd0);

  assert_clone_fanout_R1: assert property (@(posedge clk) disable iff (rst)
    (plain_acc && in_clone && active_mask != '0) |-> (push == active_mask));

  assert_own_only_R2: assert property (@(posedge clk) disable iff (rst)
    (plain_acc && !in_clone) |-> ($countones(push) <= 1));

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (plain_acc && in_clone && active_mask == '0) |-> ($countones(push) <= 1));

  assert_barrier_hold_R5: assert property (@(posedge clk) disable iff (rst)
    barrier_busy |-> !in_ready);

  assert_flush_squash_R6: assert property (@(posedge clk) disable iff (rst)
    (flush_vec != '0) |=> ((out_valid & $past(flush_vec)) == '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (push & q_full) == '0);

  assert_all_or_none_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> (push == '0));

  assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && active_mask == '0 && !barrier_busy));
endmodule

bind uop_fission_dispatch fission_dispatch_checker #(.NCTX(NCTX)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
  .in_clone(in_clone), .push(push), .q_full(q_full), .active_mask(active_mask),
  .barrier_busy(barrier_busy), .flush_vec(flush_vec), .out_valid(out_valid)
);

// File: tb/uop_fission_dispatch_test.sv
module uop_fission_dispatch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 1'b0, in_clone = 1'b0, in_multi = 1'b0, in_ctx = 1'b0;
  logic [1:0]  in_kind = 2'd0, out_ready = 2'b00, rob_empty = 2'b11;
  logic [7:0]  in_op = '0;
  logic [15:0] in_imm_vec = '0;
  logic        in_ready;
  logic [1:0]  out_valid;
  logic [15:0] out_op, out_imm;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  uop_fission_dispatch uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_clone(in_clone), .in_multi(in_multi), .in_ctx(in_ctx), .in_op(in_op),
    .in_imm_vec(in_imm_vec), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_imm(out_imm), .rob_empty(rob_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] op_of(input int k);  return out_op[k*8 +: 8];  endfunction
  function automatic logic [7:0] imm_of(input int k); return out_imm[k*8 +: 8]; endfunction

  task automatic drive(input logic [1:0] kind, input logic clone, input logic multi,
                       input logic ctx, input logic [7:0] op,
                       input logic [7:0] imm0, input logic [7:0] imm1);
    in_kind = kind; in_clone = clone; in_multi = multi; in_ctx = ctx;
    in_op = op; in_imm_vec = {imm1, imm0}; in_valid = 1'b1;
  endtask

  task automatic send(input logic [1:0] kind, input logic clone, input logic multi,
                      input logic ctx, input logic [7:0] op,
                      input logic [7:0] imm0, input logic [7:0] imm1, input string tag);
    drive(kind, clone, multi, ctx, op, imm0, imm1);
    #1 chk(in_ready == 1'b1, tag, int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 2'b00, "R9 queues empty after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);
    @(negedge clk);

    // R1 R2 R3 R4 R8 sweep: every active set against every micro-op shape
    for (int m = 0; m < 4; m++) begin
      out_ready = 2'b11;
      send(2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'(m), 8'h00, "R8 fork accepted");
      for (int c = 0; c < 2; c++)
        for (int u = 0; u < 2; u++)
          for (int x = 0; x < 2; x++) begin
            logic [7:0] op, i0, i1;
            n++;
            op = 8'(n); i0 = 8'(n + 16); i1 = 8'(n) ^ 8'hC5;
            send(2'd0, c[0], u[0], x[0], op, i0, i1, "R7 plain accepted");
            for (int k = 0; k < 2; k++) begin
              bit t;
              logic [7:0] ei;
              if (c != 0 && m != 0) t = m[k];
              else                  t = (k == x);
              ei = (u != 0) ? ((k == 0) ? i0 : i1) : i0;
              chk(out_valid[k] == t, (c == 0) ? "R2 target" : ((m != 0) ? "R1 fanout" : "R4 fallback"),
                  int'(out_valid[k]), int'(t));
              if (t) begin
                chk(op_of(k) == op, "R3 payload", int'(op_of(k)), int'(op));
                chk(imm_of(k) == ei, "R3 lane immediate", int'(imm_of(k)), int'(ei));
              end
            end
            @(negedge clk);
            chk(out_valid == 2'b00, "R10 entry leaves on handshake", int'(out_valid), 0);
          end
    end

    // R7 all-or-nothing back-pressure and R10 ordering
    out_ready = 2'b00;
    send(2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h03, 8'h00, "R8 fork");
    for (int j = 0; j < 4; j++) send(2'd0, 1'b0, 1'b0, 1'b0, 8'(8'hA0 + j), 8'h00, 8'h00, "R7 fill");
    drive(2'd0, 1'b1, 1'b0, 1'b1, 8'hB0, 8'h5A, 8'h00);
    #1 chk(in_ready == 1'b0, "R7 clone blocked by full queue", int'(in_ready), 0);
    @(negedge clk);
    chk(out_valid[1] == 1'b0, "R7 no partial copy", int'(out_valid[1]), 0);
    out_ready = 2'b01;
    @(negedge clk);
    out_ready = 2'b00;
    #1 chk(in_ready == 1'b1, "R7 clone accepted once slot frees", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 2'b11, "R1 clone in both queues", int'(out_valid), 3);
    out_ready = 2'b01;
    for (int j = 1; j < 5; j++) begin
      logic [7:0] e;
      e = (j < 4) ? 8'(8'hA0 + j) : 8'hB0;
      chk(op_of(0) == e, "R10 order", int'(op_of(0)), int'(e));
      @(negedge clk);
    end
    chk(out_valid[0] == 1'b0, "R10 queue drained", int'(out_valid[0]), 0);
    chk(op_of(1) == 8'hB0 && imm_of(1) == 8'h5A, "R3 broadcast copy", int'(op_of(1)), 8'hB0);
    out_ready = 2'b10;
    @(negedge clk);
    out_ready = 2'b11;

    // R5 join barrier
    rob_empty = 2'b01;
    send(2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, "R5 join accepted");
    drive(2'd0, 1'b0, 1'b0, 1'b0, 8'hC0, 8'h00, 8'h00);
    for (int j = 0; j < 3; j++) begin
      #1 chk(in_ready == 1'b0, "R5 stall while busy", int'(in_ready), 0);
      @(negedge clk);
    end
    rob_empty = 2'b11;
    #1 chk(in_ready == 1'b0, "R5 release is registered", int'(in_ready), 0);
    @(negedge clk);
    #1 chk(in_ready == 1'b1, "R5 released", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid[0] == 1'b1 && op_of(0) == 8'hC0, "R5 op after release", int'(op_of(0)), 8'hC0);
    @(negedge clk);
    send(2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, "R5 join idle");
    drive(2'd0, 1'b0, 1'b0, 1'b1, 8'hC1, 8'h00, 8'h00);
    #1 chk(in_ready == 1'b1, "R5 no stall when empty", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);

    // R6 flush
    out_ready = 2'b00;
    send(2'd0, 1'b1, 1'b0, 1'b0, 8'hD0, 8'h00, 8'h00, "R6 clone");
    send(2'd0, 1'b1, 1'b0, 1'b0, 8'hD1, 8'h00, 8'h00, "R6 clone");
    send(2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, "R6 flush accepted");
    chk(out_valid == 2'b10, "R6 flushed queue only", int'(out_valid), 2);
    send(2'd0, 1'b1, 1'b0, 1'b0, 8'hD2, 8'h00, 8'h00, "R6 clone after flush");
    chk(out_valid == 2'b10, "R6 context left active set", int'(out_valid), 2);
    out_ready = 2'b10;
    for (int j = 0; j < 3; j++) begin
      chk(op_of(1) == 8'(8'hD0 + j), "R6 other queue intact", int'(op_of(1)), 8'hD0 + j);
      @(negedge clk);
    end

    // R9 reset in mid-run
    out_ready = 2'b00;
    send(2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h03, 8'h00, "R8 fork");
    send(2'd0, 1'b1, 1'b0, 1'b0, 8'hE0, 8'h00, 8'h00, "R9 fill");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 chk(out_valid == 2'b00, "R9 queues cleared", int'(out_valid), 0);
    @(negedge clk);
    send(2'd0, 1'b1, 1'b0, 1'b1, 8'hE1, 8'h00, 8'h00, "R9 ready");
    chk(out_valid == 2'b10, "R9 active set cleared", int'(out_valid), 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule